// File: doc/BRIEF.md
# Frequency-Hop Preset Sequencer

This block keeps a table of eight frequency presets. Each preset is a pair made of a 32-bit RF translation word and a 32-bit NCO phase increment. The NCO word equals the target frequency times 2^32, divided by the ADC sample rate. Software loads the table, a step count and a configuration byte through a byte-wide register write port. The block then presents the pair selected by a 3-bit index on its outputs. Downstream synthesizer and NCO logic use these words.

The index has two sources. When external hopping is off, the index is a manual field in the configuration byte. When it is on, the index is a round-robin pointer. The pointer advances by one on each rising edge of an asynchronous strobe and wraps at a programmable count of 1 to 8. A one-cycle change pulse tells consumers that the selected index or the selected words have changed. The interface is plain control: writes are accepted every cycle and there is no back-pressure.

Top module: `hop_preset_seq`

## Requirements
- R1: After reset the index is 0, both output words are 0, change_pulse is 0, external hopping is off and the step-count byte holds 8.
- R2: RF preset x is stored least-significant byte first in four consecutive addresses. Preset 0 uses addresses 0 to 3, and preset x for x = 1 to 7 uses 3+4x to 6+4x. A write shows on rf_word in the cycle after the write edge whenever x is selected.
- R3: NCO preset x is stored least-significant byte first at addresses 36+4x to 39+4x, and shows on nco_word whenever x is selected.
- R4: Address 6 is the configuration byte. When bit 2 is 0, the index equals bits 7:5.
- R5: When bit 2 of address 6 is 1, the index is the pointer and bits 7:5 are ignored. The pointer advances by one, modulo the step count, on each strobe rising edge. The strobe passes through a two-flop synchronizer, so the index changes in the third clock cycle after the strobe is first sampled high.
- R6: A strobe held high advances the pointer only once. Strobe edges while hopping is off do not move the pointer.
- R7: The step count is the byte at address 35. A value of 0 acts as 1, and values above 8 act as 8.
- R8: If the pointer is at or above a newly written step count, it returns to 0 one cycle after the write.
- R9: Turning hopping off forces the pointer to 0, so turning it on again starts the sequence at index 0.
- R10: change_pulse is high for exactly one cycle after the index, rf_word or nco_word changes, and is low otherwise. Rewriting a byte with its current value produces no pulse.
- R11: Writes to addresses 4, 5 and 68 to 127 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register byte address |
| wr_data | input | 8 | Register write data |
| hop_strobe | input | 1 | Asynchronous hop trigger, active on its rising edge |
| sel_index | output | 3 | Index of the selected preset |
| rf_word | output | 32 | Selected RF translation word |
| nco_word | output | 32 | Selected NCO phase increment |
| change_pulse | output | 1 | One-cycle pulse when the selection or its contents change |

## Verification
The manual index is swept over all eight values against table patterns that differ per preset and per byte. This separates address decode errors, byte-order errors and mux errors. For every step count from 1 to 8, a strobe train of twice the count plus one is sent, which shows whether the wrap happens at the right count and whether the sequence restarts at zero. Other patterns cover a held strobe, strobes while hopping is off, out-of-range counts and a count that shrinks under the pointer. Together these tell an edge detector apart from a level detector, and a clamp apart from a truncation. Writes of the current value and writes to unmapped addresses show that change_pulse follows real changes only.

// File: rtl/hop_pkg.sv
package hop_pkg;
  localparam int unsigned PRESETS     = 8;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ADDR_W      = 7;
  localparam int unsigned IDX_W       = $clog2(PRESETS);
  localparam int unsigned CNT_W       = $clog2(PRESETS + 1);
  localparam int unsigned RF_BASE     = 3;
  localparam int unsigned NCO_BASE    = 36;
  localparam int unsigned CFG_ADDR    = 6;
  localparam int unsigned CNT_ADDR    = 35;
  localparam int unsigned CFG_EXT_BIT = 2;
  localparam int unsigned CFG_IDX_LSB = 5;

  // Preset 0 sits at the bottom of the map; later RF presets are offset.
  function automatic int unsigned rf_byte_addr(int unsigned x, int unsigned b);
    return (x == 0) ? b : RF_BASE + WORD_BYTES * x + b;
  endfunction

  function automatic int unsigned nco_byte_addr(int unsigned x, int unsigned b);
    return NCO_BASE + WORD_BYTES * x + b;
  endfunction
endpackage

// File: rtl/hop_edge_sync.sv
module hop_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned DEPTH = STAGES + 1;
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hop_preset_bank.sv
module hop_preset_bank
  import hop_pkg::*;
#(
  parameter int unsigned N  = PRESETS,
  parameter int unsigned WB = WORD_BYTES,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [N-1:0][WB-1:0][BYTE_W-1:0] rf_tab,
  output logic [N-1:0][WB-1:0][BYTE_W-1:0] nco_tab,
  output logic                          ext_en,
  output logic [IW-1:0]                 man_idx,
  output logic [BYTE_W-1:0]             cnt_raw
);
  localparam logic [AW-1:0]     A_CFG     = AW'(CFG_ADDR);
  localparam logic [AW-1:0]     A_CNT     = AW'(CNT_ADDR);
  localparam logic [BYTE_W-1:0] CNT_RESET = BYTE_W'(N);

  for (genvar x = 0; x < N; x++) begin : g_preset
    for (genvar b = 0; b < WB; b++) begin : g_byte
      localparam logic [AW-1:0] A_RF  = AW'(rf_byte_addr(x, b));
      localparam logic [AW-1:0] A_NCO = AW'(nco_byte_addr(x, b));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rf_tab[x][b]  <= '0;
          nco_tab[x][b] <= '0;
        end else if (wr_en) begin
          if (wr_addr == A_RF)  rf_tab[x][b]  <= wr_data;
          if (wr_addr == A_NCO) nco_tab[x][b] <= wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_en  <= 1'b0;
      man_idx <= '0;
      cnt_raw <= CNT_RESET;
    end else if (wr_en) begin
      if (wr_addr == A_CFG) begin
        ext_en  <= wr_data[CFG_EXT_BIT];
        man_idx <= wr_data[CFG_IDX_LSB +: IW];
      end
      if (wr_addr == A_CNT) cnt_raw <= wr_data;
    end
  end
endmodule

// File: rtl/hop_rr_pointer.sv
module hop_rr_pointer
  import hop_pkg::*;
#(
  parameter int unsigned N  = PRESETS,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              step,
  input  logic [BYTE_W-1:0] cnt_raw,
  output logic [IW-1:0]     ptr,
  output logic [CW-1:0]     cnt_eff
);
  localparam logic [BYTE_W-1:0] MAXC = BYTE_W'(N);
  localparam logic [CW-1:0]     MAXW = CW'(N);
  localparam logic [CW-1:0]     ONE  = CW'(1);

  logic [CW-1:0] ptr_ext;
  logic [CW-1:0] ptr_inc;

  always_comb begin
    if (cnt_raw == '0)      cnt_eff = ONE;
    else if (cnt_raw > MAXC) cnt_eff = MAXW;
    else                    cnt_eff = cnt_raw[CW-1:0];
  end

  assign ptr_ext = CW'(ptr);
  assign ptr_inc = ptr_ext + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr <= '0;
    else if (!enable)           ptr <= '0;
    else if (ptr_ext >= cnt_eff) ptr <= '0;
    else if (step)              ptr <= (ptr_inc >= cnt_eff) ? '0 : ptr_inc[IW-1:0];
  end
endmodule

// File: rtl/hop_preset_seq.sv
module hop_preset_seq
  import hop_pkg::*;
#(
  parameter int unsigned N_PRESETS   = PRESETS,
  parameter int unsigned N_BYTES     = WORD_BYTES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              hop_strobe,
  output logic [IDX_W-1:0]  sel_index,
  output logic [N_BYTES*BYTE_W-1:0] rf_word,
  output logic [N_BYTES*BYTE_W-1:0] nco_word,
  output logic              change_pulse
);
  localparam int unsigned WW = N_BYTES * BYTE_W;

  logic [N_PRESETS-1:0][N_BYTES-1:0][BYTE_W-1:0] rf_tab;
  logic [N_PRESETS-1:0][N_BYTES-1:0][BYTE_W-1:0] nco_tab;
  logic              ext_en;
  logic [IDX_W-1:0]  man_idx;
  logic [BYTE_W-1:0] cnt_raw;
  logic [CNT_W-1:0]  cnt_eff;
  logic [IDX_W-1:0]  ptr_q;
  logic              strobe_rise;
  logic [IDX_W-1:0]  last_idx;
  logic [WW-1:0]     last_rf;
  logic [WW-1:0]     last_nco;

  hop_preset_bank #(.N(N_PRESETS), .WB(N_BYTES), .AW(ADDR_W), .IW(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rf_tab(rf_tab), .nco_tab(nco_tab), .ext_en(ext_en), .man_idx(man_idx),
    .cnt_raw(cnt_raw)
  );

  hop_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hop_strobe), .rise(strobe_rise)
  );

  hop_rr_pointer #(.N(N_PRESETS), .IW(IDX_W), .CW(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .enable(ext_en), .step(strobe_rise),
    .cnt_raw(cnt_raw), .ptr(ptr_q), .cnt_eff(cnt_eff)
  );

  assign sel_index = ext_en ? ptr_q : man_idx;
  assign rf_word   = rf_tab[sel_index];
  assign nco_word  = nco_tab[sel_index];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_idx <= '0;
      last_rf  <= '0;
      last_nco <= '0;
    end else begin
      last_idx <= sel_index;
      last_rf  <= rf_word;
      last_nco <= nco_word;
    end
  end

  assign change_pulse = (sel_index != last_idx) || (rf_word != last_rf) ||
                        (nco_word != last_nco);
endmodule

// File: rtl/hop_seq_chk.sv
module hop_seq_chk #(
  parameter int unsigned IW = 3,
  parameter int unsigned CW = 4,
  parameter int unsigned WW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_en,
  input logic          rise,
  input logic [IW-1:0] ptr,
  input logic [CW-1:0] cnt_eff,
  input logic [IW-1:0] sel_index,
  input logic [WW-1:0] rf_word,
  input logic [WW-1:0] nco_word,
  input logic          change_pulse
);
  p_wrap_on_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && CW'(ptr) >= cnt_eff) |=> ptr == '0);

  p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |=> ptr == '0);

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ptr == $past(ptr) || ptr == '0 || ptr == $past(ptr) + IW'(1)));

  p_hold_no_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && !rise && CW'(ptr) < cnt_eff) |=> $stable(ptr));

  p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_index != $past(sel_index) || rf_word != $past(rf_word) ||
     nco_word != $past(nco_word)) |-> change_pulse);

  p_pulse_needs_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    change_pulse |-> (sel_index != $past(sel_index) || rf_word != $past(rf_word) ||
                      nco_word != $past(nco_word)));

  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_eff != '0 && cnt_eff <= CW'(8));
endmodule

bind hop_preset_seq hop_seq_chk #(.IW(hop_pkg::IDX_W), .CW(hop_pkg::CNT_W),
                                  .WW(hop_pkg::WORD_BYTES * hop_pkg::BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .rise(strobe_rise), .ptr(ptr_q),
  .cnt_eff(cnt_eff), .sel_index(sel_index), .rf_word(rf_word), .nco_word(nco_word),
  .change_pulse(change_pulse)
);

// File: tb/sim_hop_preset_seq.sv
module sim_hop_preset_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hop_strobe = 1'b0;
  logic [2:0]  sel_index;
  logic [31:0] rf_word;
  logic [31:0] nco_word;
  logic        change_pulse;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hop_preset_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hop_strobe(hop_strobe), .sel_index(sel_index), .rf_word(rf_word),
    .nco_word(nco_word), .change_pulse(change_pulse)
  );

  function automatic logic [31:0] rf_pat(int x);
    return 32'h1357_9BDF + 32'h1111_1111 * 32'(x) + 32'(x * 7);
  endfunction
  function automatic logic [31:0] nco_pat(int x);
    return 32'hF0E0_D0C0 - 32'h0102_0304 * 32'(x + 1);
  endfunction
  function automatic logic [6:0] rf_addr(int x, int b);
    return (x == 0) ? 7'(b) : 7'(3 + 4 * x + b);
  endfunction
  function automatic logic [6:0] nco_addr(int x, int b);
    return 7'(36 + 4 * x + b);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_sel(input int idx, input string tag);
    chk(32'(sel_index), 32'(idx), {tag, " index"});
    chk(rf_word, rf_pat(idx), {tag, " rf"});
    chk(nco_word, nco_pat(idx), {tag, " nco"});
  endtask

  // Pulse the strobe; index moves in the third cycle after first sample (R5).
  task automatic strobe(input logic exp_pulse);
    @(negedge clk); hop_strobe = 1'b1;
    repeat (3) @(negedge clk);
    chk(32'(change_pulse), 32'(exp_pulse), "R10 pulse after hop");
    hop_strobe = 1'b0;
    @(negedge clk);
    chk(32'(change_pulse), 32'h0, "R10 pulse one cycle");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(32'(sel_index), 0, "R1 index");
    chk(rf_word, 0, "R1 rf");
    chk(nco_word, 0, "R1 nco");
    chk(32'(change_pulse), 0, "R1 pulse");

    // R10 content change of the selected preset
    wr(7'd0, 8'h5A);
    chk(rf_word, 32'h5A, "R2 first byte");
    chk(32'(change_pulse), 1, "R10 pulse on content");
    @(negedge clk);
    chk(32'(change_pulse), 0, "R10 pulse drops");
    wr(7'd0, 8'h5A);
    chk(32'(change_pulse), 0, "R10 same value no pulse");

    // Load the whole table, LSB first (R2, R3)
    for (int x = 0; x < 8; x++)
      for (int b = 0; b < 4; b++) begin
        wr(rf_addr(x, b), rf_pat(x)[8*b +: 8]);
        wr(nco_addr(x, b), nco_pat(x)[8*b +: 8]);
      end

    // R4 manual sweep
    for (int i = 0; i < 8; i++) begin
      wr(7'd6, 8'(i << 5));
      chk_sel(i, "R4 R2 R3 manual");
    end

    // R11 unmapped writes
    wr(7'd4, 8'hFF);
    wr(7'd5, 8'hFF);
    for (int a = 68; a < 128; a++) wr(7'(a), 8'hFF);
    @(negedge clk);
    chk(32'(change_pulse), 0, "R11 no pulse");
    for (int i = 0; i < 8; i++) begin
      wr(7'd6, 8'(i << 5));
      chk_sel(i, "R11 table intact");
    end

    // R5 R9 step-count sweep
    for (int n = 1; n <= 8; n++) begin
      wr(7'd35, 8'(n));
      wr(7'd6, 8'hA4);
      chk_sel(0, "R9 R5 start at 0");
      for (int k = 1; k <= 2 * n + 1; k++) begin
        strobe(n > 1);
        chk_sel(k % n, "R5 round robin");
      end
      wr(7'd6, 8'h00);
    end

    // R6 held strobe and strobes while off
    wr(7'd35, 8'd8);
    wr(7'd6, 8'h04);
    @(negedge clk); hop_strobe = 1'b1;
    repeat (20) @(negedge clk);
    chk_sel(1, "R6 held strobe");
    hop_strobe = 1'b0;
    repeat (4) @(negedge clk);
    wr(7'd6, 8'h00);
    repeat (2) strobe(1'b0);
    wr(7'd6, 8'h04);
    chk_sel(0, "R6 R9 off strobes ignored");

    // R7 clamp low
    wr(7'd35, 8'd0);
    strobe(1'b0);
    strobe(1'b0);
    chk_sel(0, "R7 zero acts as one");
    // R7 clamp high
    wr(7'd35, 8'd200);
    for (int k = 1; k <= 7; k++) strobe(1'b1);
    chk_sel(7, "R7 large acts as eight");
    strobe(1'b1);
    chk_sel(0, "R7 wraps after eight");

    // R8 shrink under the pointer
    for (int k = 1; k <= 6; k++) strobe(1'b1);
    chk_sel(6, "R8 before shrink");
    wr(7'd35, 8'd4);
    @(negedge clk);
    chk_sel(0, "R8 wrap on shrink");
    strobe(1'b1);
    chk_sel(1, "R8 continue");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule